// File: doc/BRIEF.md
# Per-Source Trigger Interrupt Controller

The controller takes 32 interrupt request lines and combines them into one request for a parent interrupt controller. Software picks a trigger for each line with two bits, one selecting edge or level and one selecting polarity. The four choices are active-high level, active-low level, rising edge and falling edge. Each raw input first passes through a two-flop synchronizer. The controller then samples it as a level or watches it for a qualifying transition.

Every line has one status bit. In edge mode a detected transition latches the bit, and the bit stays set until software writes a one to that bit of the clear register. In level mode the bit tracks the input after the polarity is applied. A separate set register lets software raise any status bit. An enable register masks each source. The parent output is high while any status bit is set together with its enable bit.

Software reaches the registers through a word-aligned read and write port. Reads return their data one cycle after the read strobe.

Top module: `irq_trig_ctrl`

## Requirements
- R1: After reset, and again after any later reset, the enable register reads 0, the polarity register reads 0xFFFFFFFF, the edge register reads 0, the status register reads 0 while all inputs are low, and irq_out is low.
- R2: With edge bit 0 and polarity bit 1, a source's status bit follows its input: it reads 1 while the input is high and 0 once the input is low, at most four cycles after the input changes.
- R3: With edge bit 0 and polarity bit 0, a source's status bit reads 1 while its input is low and 0 while it is high.
- R4: With edge bit 1 and polarity bit 1, a 0-to-1 transition of the input sets the status bit, and the bit stays 1 after the input returns low until it is cleared.
- R5: With edge bit 1 and polarity bit 0, a 1-to-0 transition sets the status bit, and a 0-to-1 transition does not.
- R6: Writing the clear register (byte offset 0x0C) clears each edge-mode status bit where the written data has a one. Zero bits leave their status bits unchanged. A clear written to a level-mode source has no lasting effect on its status bit.
- R7: When a qualifying edge is detected in the same cycle as a clear write to that source, the status bit ends up 1.
- R8: Writing the set register (byte offset 0x08) forces each status bit where the data has a one to 1. For an edge-mode source the bit then stays 1 until it is cleared.
- R9: irq_out is high exactly when some status bit and its enable bit (byte offset 0x04) are both 1. Clearing an enable bit masks its source without changing the status bit.
- R10: bus_rdata takes the addressed value in the cycle after bus_rd. The set and clear offsets read as 0. Any other offset than 0x00, 0x04, 0x10 and 0x14 reads as 0. Writes to the status offset (0x00) are ignored.
- R11: The enable, polarity (0x10) and edge (0x14) registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 32 | Raw interrupt request lines, asynchronous |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as the edge detector fires. The detector fires only after the input has crossed both synchronizer stages. The stimulus raises a source's input on a falling clock edge and counts two rising edges. It then presents the clear write so that it is captured on the third rising edge, the same edge on which the transition is detected. The bench reads the status back afterwards and expects the bit to be set. It also confirms that a later clear does remove the bit.

// File: rtl/trigctl_pkg.sv
package trigctl_pkg;

    // Register address width and byte offsets of the register window
    localparam int AW = 8;
    localparam logic [AW-1:0] OFS_STAT = 8'h00;
    localparam logic [AW-1:0] OFS_EN   = 8'h04;
    localparam logic [AW-1:0] OFS_SET  = 8'h08;
    localparam logic [AW-1:0] OFS_CLR  = 8'h0C;
    localparam logic [AW-1:0] OFS_POL  = 8'h10;
    localparam logic [AW-1:0] OFS_EDGE = 8'h14;

    // Default number of sources
    localparam int NSRC_DEF = 32;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_EN,
        SEL_SET,
        SEL_CLR,
        SEL_POL,
        SEL_EDGE
    } reg_sel_e;

    // Per-source trigger configuration
    typedef struct packed {
        logic edge_md;   // 1: edge triggered, 0: level
        logic pol;       // 1: high / rising, 0: low / falling
    } trig_cfg_t;

    function automatic reg_sel_e map_offset(input logic [AW-1:0] a);
        reg_sel_e s;
        if (a[1:0] != 2'b00) begin
            s = SEL_NONE;
        end else begin
            case (a)
                OFS_STAT: s = SEL_STAT;
                OFS_EN:   s = SEL_EN;
                OFS_SET:  s = SEL_SET;
                OFS_CLR:  s = SEL_CLR;
                OFS_POL:  s = SEL_POL;
                OFS_EDGE: s = SEL_EDGE;
                default:  s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    // Level request after polarity is applied
    function automatic logic level_req(input logic cur, input trig_cfg_t c);
        return (cur == c.pol);
    endfunction

    // Qualifying transition between last and current synchronized sample
    function automatic logic edge_req(input logic cur, input logic prev,
                                      input trig_cfg_t c);
        return c.pol ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/trigctl_sync.sv
module trigctl_sync #(
    parameter int W = trigctl_pkg::NSRC_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign d_sync = stage2;
endmodule

// File: rtl/trigctl_detect.sv
module trigctl_detect
    import trigctl_pkg::*;
#(
    parameter int N = NSRC_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sync_in,
    input  logic [N-1:0] edge_md,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] stat
);
    logic [N-1:0] prev_q;
    logic [N-1:0] stat_q;
    logic [N-1:0] stat_d;

    for (genvar g = 0; g < N; g++) begin : g_src
        trig_cfg_t cfg;
        assign cfg.edge_md = edge_md[g];
        assign cfg.pol     = pol[g];
        // An edge beats a clear in the same cycle; set is an OR term
        assign stat_d[g] = cfg.edge_md
            ? ((stat_q[g] & ~clr_mask[g]) | set_mask[g]
               | edge_req(sync_in[g], prev_q[g], cfg))
            : (level_req(sync_in[g], cfg) | set_mask[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= sync_in;
            stat_q <= stat_d;
        end
    end

    assign stat = stat_q;
endmodule

// File: rtl/trigctl_regs.sv
module trigctl_regs
    import trigctl_pkg::*;
#(
    parameter int N = NSRC_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    input  logic [N-1:0]  stat,
    output logic [N-1:0]  rdata,
    output logic [N-1:0]  en_q,
    output logic [N-1:0]  pol_q,
    output logic [N-1:0]  edge_q,
    output logic [N-1:0]  set_mask,
    output logic [N-1:0]  clr_mask
);
    reg_sel_e     sel;
    logic [N-1:0] rd_val;

    assign sel      = map_offset(addr);
    assign set_mask = (wr && sel == SEL_SET) ? wdata : '0;
    assign clr_mask = (wr && sel == SEL_CLR) ? wdata : '0;

    always_comb begin
        case (sel)
            SEL_STAT: rd_val = stat;
            SEL_EN:   rd_val = en_q;
            SEL_POL:  rd_val = pol_q;
            SEL_EDGE: rd_val = edge_q;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '1;
            edge_q <= '0;
            rdata  <= '0;
        end else begin
            if (wr) begin
                case (sel)
                    SEL_EN:   en_q   <= wdata;
                    SEL_POL:  pol_q  <= wdata;
                    SEL_EDGE: edge_q <= wdata;
                    default:  ;
                endcase
            end
            if (rd) begin
                rdata <= rd_val;
            end
        end
    end
endmodule

// File: rtl/irq_trig_ctrl.sv
module irq_trig_ctrl
    import trigctl_pkg::*;
#(
    parameter int N = NSRC_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  bus_wdata,
    output logic [N-1:0]  bus_rdata,
    input  logic [N-1:0]  src_in,
    output logic          irq_out
);
    logic [N-1:0] src_sync;
    logic [N-1:0] en_q;
    logic [N-1:0] pol_q;
    logic [N-1:0] edge_q;
    logic [N-1:0] set_mask;
    logic [N-1:0] clr_mask;
    logic [N-1:0] stat_q;

    trigctl_sync #(.W(N)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (src_in),
        .d_sync  (src_sync)
    );

    trigctl_regs #(.N(N)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .stat     (stat_q),
        .rdata    (bus_rdata),
        .en_q     (en_q),
        .pol_q    (pol_q),
        .edge_q   (edge_q),
        .set_mask (set_mask),
        .clr_mask (clr_mask)
    );

    trigctl_detect #(.N(N)) u_det (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (src_sync),
        .edge_md  (edge_q),
        .pol      (pol_q),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .stat     (stat_q)
    );

    assign irq_out = |(stat_q & en_q);
endmodule

// File: rtl/trigctl_chk.sv
module trigctl_chk
    import trigctl_pkg::*;
#(
    parameter int N = NSRC_DEF
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic [N-1:0]  bus_wdata,
    input logic [N-1:0]  bus_rdata,
    input logic          irq_out,
    input logic [N-1:0]  en_q,
    input logic [N-1:0]  edge_q,
    input logic [N-1:0]  stat_q
);
    logic         addr_known;
    logic [N-1:0] clr_bits;

    assign addr_known = (bus_addr == OFS_STAT) || (bus_addr == OFS_EN) ||
                        (bus_addr == OFS_POL)  || (bus_addr == OFS_EDGE);
    assign clr_bits   = (bus_wr && bus_addr == OFS_CLR) ? bus_wdata : '0;

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_out);

    // R9
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (stat_q != '0));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !addr_known) |=> (bus_rdata == '0));

    // R8
    set_forces_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SET)
        |=> ((stat_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((edge_q & stat_q & ~clr_bits) != '0)
        |=> (($past(edge_q & stat_q & ~clr_bits) & ~stat_q) == '0));
endmodule

bind irq_trig_ctrl trigctl_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .en_q      (en_q),
    .edge_q    (edge_q),
    .stat_q    (stat_q)
);

// File: tb/sim_irq_trig_ctrl.sv
`timescale 1ns/1ps
module sim_irq_trig_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_trig_ctrl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_out(irq_out)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_DRV = 2'd2, OP_IRQ = 2'd3;
    localparam int NV = 56;
    // {op, requirement, offset, data, expected}
    localparam logic [77:0] VEC [NV] = '{
        {OP_RD,  4'd1,  8'h04, 32'h0, 32'h0},         // R1 enable
        {OP_RD,  4'd1,  8'h10, 32'h0, 32'hFFFFFFFF},  // R1 polarity
        {OP_RD,  4'd1,  8'h14, 32'h0, 32'h0},         // R1 edge
        {OP_RD,  4'd1,  8'h00, 32'h0, 32'h0},         // R1 status
        {OP_IRQ, 4'd1,  8'h00, 32'h0, 32'h0},         // R1 irq low
        {OP_DRV, 4'd2,  8'h00, 32'h5, 32'h0},
        {OP_RD,  4'd2,  8'h00, 32'h0, 32'h5},         // R2 high level
        {OP_IRQ, 4'd9,  8'h00, 32'h0, 32'h0},         // R9 masked
        {OP_WR,  4'd9,  8'h04, 32'h4, 32'h0},
        {OP_IRQ, 4'd9,  8'h00, 32'h0, 32'h1},         // R9 enabled
        {OP_DRV, 4'd2,  8'h00, 32'h0, 32'h0},
        {OP_RD,  4'd2,  8'h00, 32'h0, 32'h0},         // R2 follows low
        {OP_IRQ, 4'd9,  8'h00, 32'h0, 32'h0},
        {OP_WR,  4'd3,  8'h10, 32'hFFFFFFFD, 32'h0},
        {OP_RD,  4'd3,  8'h00, 32'h0, 32'h2},         // R3 low level active
        {OP_WR,  4'd6,  8'h0C, 32'h2, 32'h0},
        {OP_RD,  4'd6,  8'h00, 32'h0, 32'h2},         // R6 level not cleared
        {OP_DRV, 4'd3,  8'h00, 32'h2, 32'h0},
        {OP_RD,  4'd3,  8'h00, 32'h0, 32'h0},         // R3 inactive when high
        {OP_WR,  4'd11, 8'h10, 32'hFFFFFFFF, 32'h0},
        {OP_DRV, 4'd11, 8'h00, 32'h0, 32'h0},
        {OP_WR,  4'd11, 8'h14, 32'h8, 32'h0},
        {OP_RD,  4'd11, 8'h14, 32'h0, 32'h8},         // R11 edge readback
        {OP_DRV, 4'd4,  8'h00, 32'h8, 32'h0},
        {OP_RD,  4'd4,  8'h00, 32'h0, 32'h8},         // R4 rising latched
        {OP_DRV, 4'd4,  8'h00, 32'h0, 32'h0},
        {OP_RD,  4'd4,  8'h00, 32'h0, 32'h8},         // R4 held
        {OP_WR,  4'd9,  8'h04, 32'h8, 32'h0},
        {OP_IRQ, 4'd9,  8'h00, 32'h0, 32'h1},         // R9
        {OP_WR,  4'd6,  8'h0C, 32'hFFFFFFF7, 32'h0},
        {OP_RD,  4'd6,  8'h00, 32'h0, 32'h8},         // R6 zero bits
        {OP_WR,  4'd6,  8'h0C, 32'h8, 32'h0},
        {OP_RD,  4'd6,  8'h00, 32'h0, 32'h0},         // R6 cleared
        {OP_IRQ, 4'd9,  8'h00, 32'h0, 32'h0},
        {OP_WR,  4'd5,  8'h14, 32'h18, 32'h0},
        {OP_WR,  4'd5,  8'h10, 32'hFFFFFFEF, 32'h0},
        {OP_DRV, 4'd5,  8'h00, 32'h10, 32'h0},
        {OP_RD,  4'd5,  8'h00, 32'h0, 32'h0},         // R5 rising ignored
        {OP_DRV, 4'd5,  8'h00, 32'h0, 32'h0},
        {OP_RD,  4'd5,  8'h00, 32'h0, 32'h10},        // R5 falling latched
        {OP_WR,  4'd6,  8'h0C, 32'h10, 32'h0},
        {OP_RD,  4'd6,  8'h00, 32'h0, 32'h0},
        {OP_WR,  4'd8,  8'h08, 32'h10, 32'h0},
        {OP_RD,  4'd8,  8'h00, 32'h0, 32'h10},        // R8 software set
        {OP_WR,  4'd8,  8'h0C, 32'h10, 32'h0},
        {OP_RD,  4'd10, 8'h08, 32'h0, 32'h0},         // R10 set reads 0
        {OP_RD,  4'd10, 8'h0C, 32'h0, 32'h0},         // R10 clear reads 0
        {OP_RD,  4'd10, 8'h18, 32'h0, 32'h0},         // R10 unmapped
        {OP_RD,  4'd10, 8'h40, 32'h0, 32'h0},
        {OP_RD,  4'd10, 8'h02, 32'h0, 32'h0},
        {OP_WR,  4'd10, 8'h00, 32'hFFFFFFFF, 32'h0},
        {OP_RD,  4'd10, 8'h00, 32'h0, 32'h0},         // R10 status read-only
        {OP_WR,  4'd11, 8'h04, 32'hA5A50F0F, 32'h0},
        {OP_RD,  4'd11, 8'h04, 32'h0, 32'hA5A50F0F},  // R11 enable readback
        {OP_RD,  4'd11, 8'h10, 32'h0, 32'hFFFFFFEF},  // R11 polarity readback
        {OP_WR,  4'd11, 8'h04, 32'h0, 32'h0}
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        idle(2);
    endtask

    task automatic do_rd(input int req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
        idle(2);
    endtask

    task automatic do_drv(input logic [31:0] d);
        @(negedge clk);
        src_in = d;
        idle(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        for (int i = 0; i < NV; i++) begin
            logic [77:0] v;
            v = VEC[i];
            case (v[77:76])
                OP_WR:  do_wr(v[71:64], v[63:32]);
                OP_RD:  do_rd(int'(v[75:72]), v[71:64], v[31:0]);
                OP_DRV: do_drv(v[63:32]);
                default: begin
                    @(negedge clk);
                    check(int'(v[75:72]), {31'b0, irq_out}, v[31:0]);
                end
            endcase
        end

        // R7: clear write captured on the edge where the rising edge is detected
        @(negedge clk);
        src_in = 32'h8;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h8;
        @(negedge clk);
        bus_wr = 1'b0;
        idle(2);
        do_rd(7, 8'h00, 32'h8);   // R7 edge wins
        do_wr(8'h0C, 32'h8);
        do_rd(7, 8'h00, 32'h0);   // R7 later clear works
        do_drv(32'h0);

        // R9: masking keeps the status bit
        do_wr(8'h08, 32'h8);
        do_wr(8'h04, 32'h8);
        @(negedge clk);
        check(9, {31'b0, irq_out}, 32'h1);   // R9 pending and enabled
        do_wr(8'h04, 32'h0);
        @(negedge clk);
        check(9, {31'b0, irq_out}, 32'h0);   // R9 masked
        do_rd(9, 8'h00, 32'h8);              // R9 status kept

        // R1: reset during operation
        do_wr(8'h04, 32'hFFFFFFFF);
        do_wr(8'h10, 32'h0);
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        check(1, {31'b0, irq_out}, 32'h0);   // R1 irq after reset
        do_rd(1, 8'h04, 32'h0);              // R1 enable
        do_rd(1, 8'h10, 32'hFFFFFFFF);       // R1 polarity
        do_rd(1, 8'h14, 32'h0);              // R1 edge
        do_rd(1, 8'h00, 32'h0);              // R1 status

        finish_run();
    end
endmodule